// File: doc/BRIEF.md
# Power-Up Strap Capture and Output Mode Resolver

This block sits beside the clock-synthesis core of a clock generator. For a fixed number of reference-clock cycles after a power-up reset, four dual-use pins stay high-impedance so the board can set them with pull resistors. The block samples those pins once on the last cycle of that window. It keeps the values until the next power-up reset. From then on it enables the pins as clock outputs.

From the captured straps and the control-register fields it resolves several results. The first is the 3-bit frequency select code, taken either from the straps or from software. The second is the output mode: all high-impedance, test, or normal with spread spectrum on or off. The block also decides whether two further shared pins act as active-low stop inputs or as clock outputs. In test mode the reference input carries an external test clock, and the block produces the divided test clocks from it: CPU and SDRAM at one half, PCI at one quarter. REF and IOAPIC forward the test clock directly whenever `test_mode` is high.

Top module: `strapmode_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `strap_done`, `strap_oe`, `clk_oe`, `pm_oe`, `pm_in_mode`, `run_en`, `spread_en`, `test_mode`, `tst_cpu`, `tst_pci` and `tst_sdram` are all 0.
- R2: Counting rising edges after `rst` falls, the straps are captured at edge WIN_CYCLES, where `strap_done` rises. `strap_oe` (all four bits) and `clk_oe` are 0 up to that edge and rise at edge WIN_CYCLES+1, unless the mode is high-impedance.
- R3: A strap whose `strap_drv` bit is 0 is captured as 1. Otherwise the value of its `strap_pin` bit is captured. Bit order is [0]=S0, [1]=S1, [2]=S2, [3]=MODE.
- R4: After capture, changes on `strap_pin` or `strap_drv` have no effect until the next `rst`.
- R5: One cycle after the inputs, `freq_sel` equals the captured {S2,S1,S0} when `sel_from_sw`=0 and equals `sw_sel` when `sel_from_sw`=1.
- R6: `mode_code` 2'b11 sets `hiz_mode` and forces `strap_oe`, `clk_oe` and `pm_oe` to 0. 2'b01 is test mode, 2'b10 is normal with spread requested, and 2'b00 is normal with spread off. Flags follow one cycle after the input.
- R7: `spread_en` is 1 only after capture, with `mode_code`=2'b10 and the effective select code equal to 3'b111.
- R8: With MODE captured as 1, `pm_oe`=2'b11 (clock outputs), `pm_in_mode`=0 and `run_en`=2'b11. With MODE captured as 0, `pm_oe`=0, `pm_in_mode`=1, and `run_en[0]` (PCI) and `run_en[1]` (CPU) follow the active-low stop pins `pm_pin[0]` and `pm_pin[1]` one cycle later.
- R9: `test_mode` is 1 only after capture with `mode_code`=2'b01. On the first cycle it reads 1, `tst_cpu`, `tst_sdram` and `tst_pci` are all 0. After k further cycles, `tst_cpu`=`tst_sdram`=k mod 2 and `tst_pci`=(k/2) mod 2.
- R10: Once `test_mode` has been 0 for one cycle, the divided test clocks are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (test clock in test mode) |
| rst | input | 1 | Synchronous active-high power-up reset |
| strap_pin | input | 4 | Pin levels {MODE,S2,S1,S0} |
| strap_drv | input | 4 | 1 where a pin is externally driven |
| sel_from_sw | input | 1 | 1: take select from software |
| sw_sel | input | 3 | Software select {S2,S1,S0} |
| mode_code | input | 2 | Output mode field |
| pm_pin | input | 2 | Stop pins, active low: [0] PCI, [1] CPU |
| strap_done | output | 1 | Straps captured |
| strap_oe | output | 4 | Output enables of the strap pins |
| clk_oe | output | 1 | Enable for all other clock outputs |
| pm_oe | output | 2 | Output enables of the two stop pins |
| pm_in_mode | output | 1 | Stop pins act as inputs |
| run_en | output | 2 | [0] PCI clocks run, [1] CPU clocks run |
| freq_sel | output | 3 | Effective frequency select |
| spread_en | output | 1 | Spread spectrum active |
| test_mode | output | 1 | Test mode; REF/IOAPIC pass test clock |
| hiz_mode | output | 1 | All outputs high-impedance |
| tst_cpu | output | 1 | Test clock / 2 for CPU |
| tst_pci | output | 1 | Test clock / 4 for PCI |
| tst_sdram | output | 1 | Test clock / 2 for SDRAM |

## Verification
The bench builds the block with WIN_CYCLES=6, which keeps each power-up window short. That makes it affordable to repeat reset and capture for all 256 combinations of strap level and drive pattern, with the edge where the enables rise checked every time. With the dividers at their default depths, all 64 combinations of select source, software code and mode can be swept after one capture. A full quarter-rate period of the test clocks and the exit from test mode also come within a few dozen cycles.

// File: rtl/strapmode_pkg.sv
`timescale 1ns/1ps
package strapmode_pkg;
  localparam int SEL_W   = 3;
  localparam int STRAP_W = 4;
  localparam int IDX_MODE = 3;
  localparam logic [SEL_W-1:0] SPREAD_CODE = 3'b111;

  typedef enum logic [1:0] {
    OM_NORMAL = 2'b00,
    OM_TEST   = 2'b01,
    OM_SPREAD = 2'b10,
    OM_HIZ    = 2'b11
  } out_mode_e;
endpackage

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
module strap_capture #(
  parameter int WIN_CYCLES = 4096,
  parameter int STRAP_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] pin,
  input  logic [STRAP_W-1:0] drv,
  output logic               done,
  output logic [STRAP_W-1:0] latched
);
  localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0]      win_cnt;
  logic [STRAP_W-1:0] resolved;

  // an undriven pin rests on its internal pull-up
  assign resolved = pin | ~drv;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      done    <= 1'b0;
      latched <= '1;
    end else if (!done) begin
      if (win_cnt == LAST) begin
        latched <= resolved;
        done    <= 1'b1;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mode_resolve.sv
`timescale 1ns/1ps
module mode_resolve
  import strapmode_pkg::*;
#(
  parameter int NSHARE = 4,
  parameter int NPM    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               done,
  input  logic [STRAP_W-1:0] latched,
  input  logic               sel_from_sw,
  input  logic [SEL_W-1:0]   sw_sel,
  input  logic [1:0]         mode_code,
  input  logic [NPM-1:0]     pm_pin,
  output logic [NSHARE-1:0]  strap_oe,
  output logic               clk_oe,
  output logic [NPM-1:0]     pm_oe,
  output logic               pm_in_mode,
  output logic [NPM-1:0]     run_en,
  output logic [SEL_W-1:0]   freq_sel,
  output logic               spread_en,
  output logic               test_mode,
  output logic               hiz_mode
);
  out_mode_e        om;
  logic [SEL_W-1:0] sel_n;
  logic             live;
  logic             pm_is_clk;

  assign om        = out_mode_e'(mode_code);
  assign sel_n     = sel_from_sw ? sw_sel : latched[SEL_W-1:0];
  assign live      = done && (om != OM_HIZ);
  assign pm_is_clk = latched[IDX_MODE];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_oe     <= 1'b0;
      pm_in_mode <= 1'b0;
      freq_sel   <= SPREAD_CODE;
      spread_en  <= 1'b0;
      test_mode  <= 1'b0;
      hiz_mode   <= 1'b0;
    end else begin
      clk_oe     <= live;
      pm_in_mode <= done && !pm_is_clk;
      freq_sel   <= sel_n;
      spread_en  <= done && (om == OM_SPREAD) && (sel_n == SPREAD_CODE);
      test_mode  <= done && (om == OM_TEST);
      hiz_mode   <= (om == OM_HIZ);
    end
  end

  for (genvar i = 0; i < NSHARE; i++) begin : g_share
    always_ff @(posedge clk) begin
      if (rst) strap_oe[i] <= 1'b0;
      else     strap_oe[i] <= live;
    end
  end

  for (genvar j = 0; j < NPM; j++) begin : g_pm
    always_ff @(posedge clk) begin
      if (rst) begin
        pm_oe[j]  <= 1'b0;
        run_en[j] <= 1'b0;
      end else begin
        pm_oe[j]  <= live && pm_is_clk;
        run_en[j] <= done && (pm_is_clk || pm_pin[j]);
      end
    end
  end
endmodule

// File: rtl/test_divider.sv
`timescale 1ns/1ps
module test_divider #(
  parameter int FAST_LOG2 = 1,
  parameter int SLOW_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic fast_a,
  output logic fast_b,
  output logic slow
);
  localparam int DW = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;

  logic [DW-1:0] div_cnt;

  // held at zero outside test mode so every ratio starts low on entry
  always_ff @(posedge clk) begin
    if (rst || !run) div_cnt <= '0;
    else             div_cnt <= div_cnt + 1'b1;
  end

  assign fast_a = div_cnt[FAST_LOG2-1];
  assign fast_b = div_cnt[FAST_LOG2-1];
  assign slow   = div_cnt[SLOW_LOG2-1];
endmodule

// File: rtl/strapmode_ctrl.sv
`timescale 1ns/1ps
module strapmode_ctrl
  import strapmode_pkg::*;
#(
  parameter int WIN_CYCLES = 4096,
  parameter int FAST_LOG2  = 1,
  parameter int SLOW_LOG2  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   strap_pin,
  input  logic [3:0]   strap_drv,
  input  logic         sel_from_sw,
  input  logic [2:0]   sw_sel,
  input  logic [1:0]   mode_code,
  input  logic [1:0]   pm_pin,
  output logic         strap_done,
  output logic [3:0]   strap_oe,
  output logic         clk_oe,
  output logic [1:0]   pm_oe,
  output logic         pm_in_mode,
  output logic [1:0]   run_en,
  output logic [2:0]   freq_sel,
  output logic         spread_en,
  output logic         test_mode,
  output logic         hiz_mode,
  output logic         tst_cpu,
  output logic         tst_pci,
  output logic         tst_sdram
);
  logic [STRAP_W-1:0] latched_q;

  strap_capture #(.WIN_CYCLES(WIN_CYCLES), .STRAP_W(STRAP_W)) u_cap (
    .clk(clk), .rst(rst), .pin(strap_pin), .drv(strap_drv),
    .done(strap_done), .latched(latched_q)
  );

  mode_resolve #(.NSHARE(4), .NPM(2)) u_res (
    .clk(clk), .rst(rst), .done(strap_done), .latched(latched_q),
    .sel_from_sw(sel_from_sw), .sw_sel(sw_sel), .mode_code(mode_code),
    .pm_pin(pm_pin), .strap_oe(strap_oe), .clk_oe(clk_oe), .pm_oe(pm_oe),
    .pm_in_mode(pm_in_mode), .run_en(run_en), .freq_sel(freq_sel),
    .spread_en(spread_en), .test_mode(test_mode), .hiz_mode(hiz_mode)
  );

  test_divider #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_div (
    .clk(clk), .rst(rst), .run(test_mode),
    .fast_a(tst_cpu), .fast_b(tst_sdram), .slow(tst_pci)
  );
endmodule

// File: rtl/strapmode_ctrl_chk.sv
`timescale 1ns/1ps
module strapmode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic [3:0] latched,
  input logic [3:0] strap_oe,
  input logic       clk_oe,
  input logic [1:0] pm_oe,
  input logic       pm_in_mode,
  input logic       sel_from_sw,
  input logic [2:0] freq_sel,
  input logic       spread_en,
  input logic       test_mode,
  input logic       hiz_mode,
  input logic       tst_cpu,
  input logic       tst_pci
);
  p_oe_after_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_oe || strap_oe != 4'b0) |-> done);

  p_capture_held_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(done)) |-> $stable(latched));

  p_strap_source_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_from_sw)) |-> freq_sel == $past(latched[2:0]));

  p_hiz_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    hiz_mode |-> (!clk_oe && strap_oe == 4'b0 && pm_oe == 2'b0));

  p_spread_code_r7: assert property (@(posedge clk) disable iff (rst)
    spread_en |-> freq_sel == 3'b111);

  p_pm_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    pm_in_mode |-> pm_oe == 2'b0);

  p_div_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(test_mode) |-> (!tst_cpu && !tst_pci));

  p_div_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && test_mode && $past(test_mode)) |-> tst_cpu != $past(tst_cpu));

  p_div_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !test_mode && !$past(test_mode)) |-> (!tst_cpu && !tst_pci));
endmodule

bind strapmode_ctrl strapmode_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .done(strap_done), .latched(latched_q),
  .strap_oe(strap_oe), .clk_oe(clk_oe), .pm_oe(pm_oe), .pm_in_mode(pm_in_mode),
  .sel_from_sw(sel_from_sw), .freq_sel(freq_sel), .spread_en(spread_en),
  .test_mode(test_mode), .hiz_mode(hiz_mode), .tst_cpu(tst_cpu), .tst_pci(tst_pci)
);

// File: tb/strapmode_ctrl_test.sv
`timescale 1ns/1ps
module strapmode_ctrl_test;
  localparam int WIN = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] strap_pin, strap_drv;
  logic       sel_from_sw;
  logic [2:0] sw_sel;
  logic [1:0] mode_code, pm_pin;
  logic       strap_done, clk_oe, pm_in_mode, spread_en, test_mode, hiz_mode;
  logic       tst_cpu, tst_pci, tst_sdram;
  logic [3:0] strap_oe;
  logic [1:0] pm_oe, run_en;
  logic [2:0] freq_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  strapmode_ctrl #(.WIN_CYCLES(WIN)) uut (
    .clk(clk), .rst(rst), .strap_pin(strap_pin), .strap_drv(strap_drv),
    .sel_from_sw(sel_from_sw), .sw_sel(sw_sel), .mode_code(mode_code),
    .pm_pin(pm_pin), .strap_done(strap_done), .strap_oe(strap_oe),
    .clk_oe(clk_oe), .pm_oe(pm_oe), .pm_in_mode(pm_in_mode), .run_en(run_en),
    .freq_sel(freq_sel), .spread_en(spread_en), .test_mode(test_mode),
    .hiz_mode(hiz_mode), .tst_cpu(tst_cpu), .tst_pci(tst_pci),
    .tst_sdram(tst_sdram)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // reset, then advance to the negedge that follows capture edge WIN
  task automatic power_up(input logic [3:0] pin, input logic [3:0] drv);
    rst = 1'b1;
    strap_pin = pin;
    strap_drv = drv;
    step(2);
    check("R1 oe in reset", {strap_oe, clk_oe, pm_oe, run_en, test_mode, tst_pci}, 0);
    rst = 1'b0;
    step(WIN - 1);
    check("R2 not captured early", {strap_done, strap_oe, clk_oe}, 0);
    step(1);
    check("R2 capture edge", {strap_done, strap_oe, clk_oe}, {1'b1, 4'b0, 1'b0});
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    strap_pin = '0; strap_drv = '0;
    sel_from_sw = 1'b0; sw_sel = '0; mode_code = 2'b10; pm_pin = 2'b00;
    @(negedge clk);

    // R1: first cycle after reset
    rst = 1'b1; step(2); rst = 1'b0; step(1);
    check("R1 first cycle", {strap_done, strap_oe, clk_oe, pm_oe, pm_in_mode,
          run_en, spread_en, test_mode, tst_cpu, tst_pci, tst_sdram}, 0);

    // R2 R3 R5 R7 R8: all strap level / drive combinations, spread requested
    for (int p = 0; p < 16; p++) begin
      for (int d = 0; d < 16; d++) begin
        logic [3:0] eff;
        eff = 4'(p) | ~4'(d);
        power_up(4'(p), 4'(d));
        step(1);
        check("R2 enables rise", {strap_oe, clk_oe}, 5'b11111);
        check("R3 R5 captured select", freq_sel, eff[2:0]);
        check("R7 spread on 111", spread_en, (eff[2:0] == 3'b111));
        check("R8 pm pins", {pm_oe, pm_in_mode, run_en},
              eff[3] ? {2'b11, 1'b0, 2'b11} : {2'b00, 1'b1, 2'b00});
      end
    end

    // R4: capture S=101 MODE=0 then disturb the pins
    power_up(4'b0101, 4'b1111);
    strap_pin = 4'b1010;
    strap_drv = 4'b0000;
    step(3);
    check("R4 straps held", {freq_sel, pm_in_mode}, {3'b101, 1'b1});

    // R5 R6 R7 R9: sweep select source, software code and mode
    for (int c = 0; c < 64; c++) begin
      logic [2:0] es;
      logic [1:0] m;
      sel_from_sw = c[5];
      sw_sel = c[4:2];
      mode_code = c[1:0];
      m = c[1:0];
      es = c[5] ? c[4:2] : 3'b101;
      step(1);
      check("R5 select source", freq_sel, es);
      check("R6 mode flags", {hiz_mode, test_mode, clk_oe, strap_oe},
            {(m == 2'b11), (m == 2'b01), {5{m != 2'b11}}});
      check("R7 spread", spread_en, (m == 2'b10) && (es == 3'b111));
    end

    // R8: stop pins as inputs with MODE=0
    mode_code = 2'b00;
    for (int s = 0; s < 4; s++) begin
      pm_pin = 2'(s);
      step(1);
      check("R8 run follows stop pins", {run_en, pm_oe}, {2'(s), 2'b00});
    end

    // R9: test-mode dividers from entry
    mode_code = 2'b01;
    step(1);
    check("R9 test flag", test_mode, 1'b1);
    for (int k = 0; k < 12; k++) begin
      check("R9 divided clocks", {tst_cpu, tst_sdram, tst_pci},
            {1'(k % 2), 1'(k % 2), 1'((k / 2) % 2)});
      step(1);
    end

    // R10: leave test mode
    mode_code = 2'b00;
    step(2);
    check("R10 dividers quiet", {test_mode, tst_cpu, tst_sdram, tst_pci}, 0);
    step(3);
    check("R10 stays quiet", {tst_cpu, tst_sdram, tst_pci}, 0);

    // R9: re-entry starts low again
    mode_code = 2'b01;
    step(1);
    check("R9 re-entry low", {test_mode, tst_cpu, tst_sdram, tst_pci}, 4'b1000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule